// File: doc/BRIEF.md
# Dual Parallel Port Peripheral

This block gives a host bus 48 general-purpose lines arranged as two identical groups. Each group holds three 8-bit ports (A, B, C) and one mode register. The host reaches everything through one 8-byte register window with a 3-bit address, an 8-bit write bus, write and read strobes and a read-data bus. Every line has a pad output, a pad output enable and a pad input.

A mode word sets the direction of each group: port A and port B as whole bytes, and port C as two separate nibbles. Each port has an output latch. The latch drives its lines whenever they are outputs, and it keeps its value while the lines are inputs. A port read returns the latch for output bits and the synchronized pad level for input bits.

The register interface is a plain strobe interface and has no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read returns its data on `bus_rdata` one cycle after the edge where `bus_rd` is high. `bus_rdata` holds that value until the next read.

Top module: `pio_dual`

## Requirements
- R1: After reset, both mode registers read 0x9B, every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: Address bit 2 selects the group (0 = first, 1 = second). Address bits 1..0 select port A (0), port B (1), port C (2) or the mode register (3). Line index is group*24 + port*8 + bit, with A=0, B=1, C=2.
- R3: A mode-register write with bit 7 set updates the direction in the cycle after the write. Bit 4 sets the direction of port A and bit 1 sets the direction of port B. A value of 1 means input (`pad_oe` 0) and 0 means output (`pad_oe` 1).
- R4: A port write loads that port's latch, and `pad_out` shows the new value in the cycle after the write, whatever the direction. The latch keeps its value across direction changes, so lines that become outputs drive it at once.
- R5: In a mode word, bit 3 sets the direction of port C bits 7..4 and bit 0 sets the direction of port C bits 3..0. A value of 1 means input.
- R6: A mode-register write with bit 7 clear changes neither the direction nor the mode register read-back.
- R7: A port read returns, one cycle after `bus_rd`, the latch bits where the line is an output and the pad input bits where the line is an input. Pad inputs pass through a two-stage synchronizer. `bus_rdata` holds its value when no read is made.
- R8: A mode-register read returns the last accepted mode word, with bit 7 set.
- R9: Writing 0x80 to a mode register makes all 24 lines of that group outputs and leaves the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_rd |
| pad_out | output | 48 | Output level for each line |
| pad_oe | output | 48 | Output enable for each line, 1 = drive |
| pad_in | input | 48 | Input level from each line |

## Verification
The bench goes after the port C nibble split. A design that decoded both nibbles from a single mode bit would make the port read mix latch and pad bits wrongly. It also goes after writes to the mode register with bit 7 clear: a design that took them would drop outputs or change the read-back. The bench writes a latch while its lines are inputs and then switches them to outputs. A design that cleared the latch, or gated it by direction, would drive the wrong byte. Finally, it sends mode writes to one group and checks that the other group keeps its lines. A wrong group decode would move lines in both groups.

// File: rtl/pio_dual_pkg.sv
package pio_dual_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned PORTS_PER_G = 3;
  localparam int unsigned LINES_PER_G = BYTE_W * PORTS_PER_G;
  localparam logic [7:0]  MODE_RESET  = 8'h9B;
  localparam int unsigned BIT_MODE    = 7;
  localparam int unsigned BIT_A_IN    = 4;
  localparam int unsigned BIT_CHI_IN  = 3;
  localparam int unsigned BIT_B_IN    = 1;
  localparam int unsigned BIT_CLO_IN  = 0;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_dual_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  reg_sel_e               sel,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic [LINES_PER_G-1:0] pin_sync,
  output logic [LINES_PER_G-1:0] lat_out,
  output logic [LINES_PER_G-1:0] lat_oe,
  output logic [BYTE_W-1:0]      rd_val
);
  logic [BYTE_W-1:0] latch [PORTS_PER_G];
  logic [BYTE_W-1:0] mode_q;
  logic [LINES_PER_G-1:0] is_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      for (int p = 0; p < int'(PORTS_PER_G); p++) latch[p] <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MODE) begin
        if (wdata[BIT_MODE]) mode_q <= wdata;
      end else begin
        latch[sel] <= wdata;
      end
    end
  end

  assign is_in = {{4{mode_q[BIT_CHI_IN]}}, {4{mode_q[BIT_CLO_IN]}},
                  {BYTE_W{mode_q[BIT_B_IN]}}, {BYTE_W{mode_q[BIT_A_IN]}}};
  assign lat_oe = ~is_in;

  for (genvar p = 0; p < int'(PORTS_PER_G); p++) begin : g_port
    assign lat_out[p*BYTE_W +: BYTE_W] = latch[p];
  end

  always_comb begin
    rd_val = mode_q;
    if (sel != SEL_MODE) begin
      for (int b = 0; b < int'(BYTE_W); b++) begin
        rd_val[b] = is_in[int'(sel)*BYTE_W + b] ? pin_sync[int'(sel)*BYTE_W + b]
                                                : latch[sel][b];
      end
    end
  end
endmodule

// File: rtl/pio_dual.sv
module pio_dual
  import pio_dual_pkg::*;
#(
  parameter int unsigned NUM_GROUPS  = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int unsigned ADDR_W     = GRP_W + 2,
  localparam int unsigned LINES      = NUM_GROUPS * LINES_PER_G
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  input  logic [LINES-1:0]  pad_in
);
  logic [LINES-1:0] in_sync;
  logic [7:0]       grp_rd [NUM_GROUPS];
  logic [GRP_W-1:0] grp_idx;
  reg_sel_e         sel;

  assign grp_idx = bus_addr[ADDR_W-1:2];
  assign sel     = reg_sel_e'(bus_addr[1:0]);

  pio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
    pio_group u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && (grp_idx == GRP_W'(g))),
      .sel     (sel),
      .wdata   (bus_wdata),
      .pin_sync(in_sync[g*LINES_PER_G +: LINES_PER_G]),
      .lat_out (pad_out[g*LINES_PER_G +: LINES_PER_G]),
      .lat_oe  (pad_oe[g*LINES_PER_G +: LINES_PER_G]),
      .rd_val  (grp_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= grp_rd[grp_idx];
  end
endmodule

// File: rtl/pio_dual_chk.sv
module pio_dual_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic [47:0] pad_out,
  input logic [47:0] pad_oe
);
  AST_PORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> pad_out[7:0] == $past(bus_wdata)); // R4

  AST_MODE_DIR_A: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) |=> pad_oe[7:0] == {8{~$past(bus_wdata[4])}}); // R3

  AST_MODE_DIR_B: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) |=> pad_oe[15:8] == {8{~$past(bus_wdata[1])}}); // R3

  AST_NIBBLE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd7 && bus_wdata[7]) |=>
      (pad_oe[47:44] == {4{~$past(bus_wdata[3])}} && pad_oe[43:40] == {4{~$past(bus_wdata[0])}})); // R5

  AST_NONMODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && !bus_wdata[7]) |=> $stable(pad_oe[23:0])); // R6

  AST_OTHER_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[2]) |=> $stable(pad_oe[47:24])); // R9
endmodule

bind pio_dual pio_dual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_pio_dual.sv
module tb_pio_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] pad_out, pad_oe;
  logic [47:0] pad_in = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] q_exp [$];
  string      q_tag [$];
  logic       rd_seen = 1'b0;
  logic       done = 1'b0;

  pio_dual dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    rd_seen <= bus_rd;
    cycles  <= cycles + 1;
  end

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {40'h0, bus_rdata}, {40'h0, e});
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    bus_addr = a; bus_rd = 1'b1;
    q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", pad_oe, 48'h0);
    check("R1 out after reset", pad_out, 48'h0);
    rd(3'd3, 8'h9B, "R1 R8 mode1 reset");
    rd(3'd7, 8'h9B, "R1 R8 mode2 reset");

    pad_in = 48'hE1_5A_C3_96_3C_69;
    repeat (3) @(negedge clk);
    rd(3'd0, 8'h69, "R7 input read A1");

    wr(3'd0, 8'hA5);
    check("R4 latch while input", {40'h0, pad_out[7:0]}, {40'h0, 8'hA5});
    rd(3'd0, 8'h69, "R7 input bits show pad");

    wr(3'd3, 8'h80);
    check("R9 group1 all outputs", pad_oe, 48'h000000_FFFFFF);
    rd(3'd0, 8'hA5, "R4 R7 latch driven after switch");
    rd(3'd3, 8'h80, "R8 mode readback");

    wr(3'd3, 8'h05);
    check("R6 oe kept", pad_oe, 48'h000000_FFFFFF);
    rd(3'd3, 8'h80, "R6 readback kept");

    wr(3'd7, 8'h88);
    check("R5 upper C input", pad_oe, 48'h0FFFFF_FFFFFF);
    wr(3'd6, 8'h3C);
    rd(3'd6, 8'hEC, "R5 R7 mixed C read");
    wr(3'd7, 8'h81);
    check("R5 lower C input", pad_oe, 48'hF0FFFF_FFFFFF);
    rd(3'd6, 8'h31, "R5 R7 mixed C read swap");

    wr(3'd4, 8'h12);
    wr(3'd5, 8'h34);
    wr(3'd1, 8'h77);
    check("R2 line map", pad_out, 48'h3C3412_0077A5);

    wr(3'd3, 8'h92);
    check("R3 A B input C output", pad_oe, 48'hF0FFFF_FF0000);
    rd(3'd1, 8'h3C, "R3 R7 B input read");
    rd(3'd7, 8'h81, "R2 R8 group2 mode");

    wr(3'd2, 8'h55);
    @(negedge clk);
    check("R7 rdata held", {40'h0, bus_rdata}, {40'h0, 8'h81});
    check("R4 C latch out", {40'h0, pad_out[23:16]}, {40'h0, 8'h55});

    repeat (2) @(negedge clk);
    if (q_exp.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q_exp.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule